// File: doc/BRIEF.md
# Power-Management Register File with Interrupt Logic

This block is the register file of a power-management companion device. A host reaches it through a single-cycle port that carries a 5-bit index, a write strobe and 16-bit data. Reads come back one cycle later on a registered data output. Most locations are plain control storage. A few have side effects: an interrupt status word that is toggled by XOR, a mask that gates that word onto one interrupt line, a converter result window that also selects a channel, a sample-control word whose written ones clear bits, and a watchdog location that can request a system shutdown.

A power-key input raises an interrupt source and updates a level bit in a read-only status word. Conversion results come from a parameter table. The clock, audio and miscellaneous analog locations are placeholders: they read zero and drop writes. Five indices are not decoded at all, and any access to one of them sets a sticky error output.

Top module: `pmr_regfile`

## Requirements
- R1: After reset the mask reads 0xFFFF, the interrupt status 0x0000, the status word 0x0020, calibration 0x0001, both control words 0x0000, sample control the SMP_RST parameter, and the selected channel is 0. The outputs irq_o, shutdown_o and err_o are all low.
- R2: irq_o is high exactly when some interrupt status bit is 1 while the same mask bit is 0. It follows a write from the cycle after the write.
- R3: A write to index 0x01 XORs the data into the interrupt status. A read of index 0x01 returns the status.
- R4: Index 0x02 holds the interrupt mask and can be read and written.
- R5: Index 0x00 reads 0x0215 with bit 7 equal to the variant_i strap. Writes to it are ignored.
- R6: A read of index 0x08 returns the selected channel in bits [13:10] and that channel's 10-bit result in bits [9:0], with bits [15:14] zero. A write to index 0x08 selects the channel given in data bits [13:10] and sets interrupt status bit 8.
- R7: A channel whose bit in ADC_USED is 0 returns a result field of zero.
- R8: A write to index 0x09 clears every sample-control bit for which the written data bit is 1, and leaves the other bits unchanged.
- R9: Index 0x06 (calibration), index 0x0D (control 1) and index 0x0E (control 2) can be read and written.
- R10: A write of 0x0000 to index 0x17 while control-1 bit 1 is set raises shutdown_o for exactly the next cycle. A nonzero write, or a write while that bit is clear, leaves shutdown_o low. Index 0x17 reads zero.
- R11: A cycle with key_evt_i high sets interrupt status bit 0 and sets status-word bit 5 to the inverse of key_down_i (1 means pressed). Writes to index 0x16 are ignored.
- R12: When a write to index 0x01 and an event (key or channel select) occur in the same cycle, the XOR is applied first and the event bits are then forced to 1.
- R13: Indices 0x07 and 0x12 to 0x15 read zero, ignore writes, and set err_o, which stays high until reset. All other unlisted indices read zero and ignore writes without setting err_o.
- R14: rdata_o changes only in the cycle after a read request and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| variant_i | input | 1 | Strap that selects the identification variant bit |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 5 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| key_evt_i | input | 1 | One-cycle power-key change event |
| key_down_i | input | 1 | Key level that goes with the event (1 = pressed) |
| irq_o | output | 1 | Interrupt request |
| shutdown_o | output | 1 | One-cycle shutdown request |
| err_o | output | 1 | Sticky error flag for undefined indices |

## Verification
The hardest case to produce is a cycle in which an XOR write to the interrupt status coincides with an event that forces a bit of that same word. The bench builds it by setting status bit 0 through a key event first, then driving a key event and an XOR write of bit 0 on the same edge. It expects the bit to end up set. A second hard case is reaching the shutdown request only when the arming bit is set. The bench writes zero to the watchdog location before and after arming control 1, so that both outcomes are seen. Full sweeps over all 32 indices, all 16 channels and all 16 mask bits are compared against a software model.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    localparam int DW = 16;
    localparam int AW = 5;

    localparam logic [AW-1:0] IX_ID   = 5'h00;
    localparam logic [AW-1:0] IX_IRQ  = 5'h01;
    localparam logic [AW-1:0] IX_MASK = 5'h02;
    localparam logic [AW-1:0] IX_CAL  = 5'h06;
    localparam logic [AW-1:0] IX_ADC  = 5'h08;
    localparam logic [AW-1:0] IX_SMP  = 5'h09;
    localparam logic [AW-1:0] IX_CTL1 = 5'h0D;
    localparam logic [AW-1:0] IX_CTL2 = 5'h0E;
    localparam logic [AW-1:0] IX_STAT = 5'h16;
    localparam logic [AW-1:0] IX_WDOG = 5'h17;

    localparam logic [DW-1:0] ID_BASE  = 16'h0215;
    localparam int            ID_VAR_BIT = 7;
    localparam logic [DW-1:0] STAT_RST = 16'h0020;
    localparam int            KEY_STAT_BIT = 5;
    localparam logic [DW-1:0] CAL_RST  = 16'h0001;
    localparam logic [DW-1:0] MASK_RST = 16'hFFFF;
    localparam int            IRQ_KEY_BIT = 0;
    localparam int            IRQ_ADC_BIT = 8;
    localparam int            WDOG_ARM_BIT = 1;

    typedef enum logic [3:0] {
        RK_RSVD, RK_UNDEF, RK_ID, RK_IRQ, RK_MASK, RK_CAL,
        RK_ADC, RK_SMP, RK_CTL1, RK_CTL2, RK_STAT, RK_WDOG
    } reg_kind_e;

    function automatic reg_kind_e classify(logic [AW-1:0] ix);
        reg_kind_e k;
        case (ix)
            IX_ID:   k = RK_ID;
            IX_IRQ:  k = RK_IRQ;
            IX_MASK: k = RK_MASK;
            IX_CAL:  k = RK_CAL;
            IX_ADC:  k = RK_ADC;
            IX_SMP:  k = RK_SMP;
            IX_CTL1: k = RK_CTL1;
            IX_CTL2: k = RK_CTL2;
            IX_STAT: k = RK_STAT;
            IX_WDOG: k = RK_WDOG;
            5'h07, 5'h12, 5'h13, 5'h14, 5'h15: k = RK_UNDEF;
            default: k = RK_RSVD;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/pmr_decode.sv
module pmr_decode
    import pmr_pkg::*;
(
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] idx_i,
    output reg_kind_e     kind_o,
    output logic          wr_o,
    output logic          rd_o
);
    always_comb begin
        kind_o = classify(idx_i);
        wr_o   = req_i & we_i;
        rd_o   = req_i & ~we_i;
    end
endmodule

// File: rtl/pmr_irq_unit.sv
module pmr_irq_unit #(
    parameter int            W        = 16,
    parameter logic [W-1:0]  MASK_INI = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         xor_we_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] st;
        logic [W-1:0] msk;
        logic         irq;
    } irq_st_t;

    irq_st_t q, d;

    always_comb begin
        d = q;
        if (xor_we_i)  d.st  = q.st ^ wdata_i;
        d.st = d.st | set_i;
        if (mask_we_i) d.msk = wdata_i;
        d.irq = |(d.st & ~d.msk);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.st  <= '0;
            q.msk <= MASK_INI;
            q.irq <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign status_o = q.st;
    assign mask_o   = q.msk;
    assign irq_o    = q.irq;
endmodule

// File: rtl/pmr_adc_window.sv
module pmr_adc_window #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10,
    parameter int W     = 16,
    parameter logic [(1<<CH_W)*RES_W-1:0] INIT = '0,
    parameter logic [(1<<CH_W)-1:0]       USED = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         sel_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] word_o
);
    localparam int N_CH = 1 << CH_W;

    logic [RES_W-1:0] tab [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        if (USED[g]) begin : g_used
            assign tab[g] = INIT[g*RES_W +: RES_W];
        end else begin : g_empty
            assign tab[g] = '0;
        end
    end

    logic [CH_W-1:0] ch_q, ch_d;

    always_comb begin
        ch_d = ch_q;
        if (sel_we_i) ch_d = wdata_i[RES_W +: CH_W];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ch_q <= '0;
        else         ch_q <= ch_d;
    end

    assign word_o = W'({ch_q, tab[ch_q]});
endmodule

// File: rtl/pmr_regfile.sv
module pmr_regfile #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10,
    parameter logic [(1<<CH_W)*RES_W-1:0] ADC_INIT = {(1<<CH_W){10'h200}},
    parameter logic [(1<<CH_W)-1:0]       ADC_USED = '1,
    parameter logic [15:0]                SMP_RST  = 16'h00FF
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        variant_i,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [4:0]  idx_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    input  logic        key_evt_i,
    input  logic        key_down_i,
    output logic        irq_o,
    output logic        shutdown_o,
    output logic        err_o
);
    import pmr_pkg::*;

    typedef struct packed {
        logic [DW-1:0] cal;
        logic [DW-1:0] smp;
        logic [DW-1:0] c1;
        logic [DW-1:0] c2;
        logic [DW-1:0] stat;
        logic [DW-1:0] rdata;
        logic          shut;
        logic          err;
    } rf_st_t;

    rf_st_t q, d;

    reg_kind_e     kind;
    logic          acc_wr, acc_rd;
    logic [DW-1:0] irq_status, irq_mask, irq_set, adc_word, rd_mux;

    pmr_decode u_dec (
        .req_i  (req_i),
        .we_i   (we_i),
        .idx_i  (idx_i),
        .kind_o (kind),
        .wr_o   (acc_wr),
        .rd_o   (acc_rd)
    );

    always_comb begin
        irq_set = '0;
        if (acc_wr && kind == RK_ADC) irq_set[IRQ_ADC_BIT] = 1'b1;
        if (key_evt_i)                irq_set[IRQ_KEY_BIT] = 1'b1;
    end

    pmr_irq_unit #(.W(DW), .MASK_INI(MASK_RST)) u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .xor_we_i  (acc_wr && kind == RK_IRQ),
        .mask_we_i (acc_wr && kind == RK_MASK),
        .wdata_i   (wdata_i),
        .set_i     (irq_set),
        .status_o  (irq_status),
        .mask_o    (irq_mask),
        .irq_o     (irq_o)
    );

    pmr_adc_window #(
        .CH_W (CH_W), .RES_W (RES_W), .W (DW),
        .INIT (ADC_INIT), .USED (ADC_USED)
    ) u_adc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_we_i (acc_wr && kind == RK_ADC),
        .wdata_i  (wdata_i),
        .word_o   (adc_word)
    );

    always_comb begin
        rd_mux = '0;
        case (kind)
            RK_ID: begin
                rd_mux = ID_BASE;
                rd_mux[ID_VAR_BIT] = variant_i;
            end
            RK_IRQ:  rd_mux = irq_status;
            RK_MASK: rd_mux = irq_mask;
            RK_CAL:  rd_mux = q.cal;
            RK_ADC:  rd_mux = adc_word;
            RK_SMP:  rd_mux = q.smp;
            RK_CTL1: rd_mux = q.c1;
            RK_CTL2: rd_mux = q.c2;
            RK_STAT: rd_mux = q.stat;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        d      = q;
        d.shut = 1'b0;
        if (acc_wr) begin
            case (kind)
                RK_CAL:   d.cal = wdata_i;
                RK_SMP:   d.smp = q.smp & ~wdata_i;
                RK_CTL1:  d.c1  = wdata_i;
                RK_CTL2:  d.c2  = wdata_i;
                RK_WDOG:  d.shut = (wdata_i == '0) && q.c1[WDOG_ARM_BIT];
                RK_UNDEF: d.err = 1'b1;
                default:  ;
            endcase
        end
        if (acc_rd) begin
            d.rdata = rd_mux;
            if (kind == RK_UNDEF) d.err = 1'b1;
        end
        if (key_evt_i) d.stat[KEY_STAT_BIT] = ~key_down_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.cal   <= CAL_RST;
            q.smp   <= SMP_RST;
            q.c1    <= '0;
            q.c2    <= '0;
            q.stat  <= STAT_RST;
            q.rdata <= '0;
            q.shut  <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rdata_o    = q.rdata;
    assign shutdown_o = q.shut;
    assign err_o      = q.err;
endmodule

// File: rtl/pmr_regfile_chk.sv
module pmr_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        we,
    input logic [4:0]  idx,
    input logic [15:0] wdata,
    input logic        key_evt,
    input logic        key_down,
    input logic        irq,
    input logic        shutdown,
    input logic        err,
    input logic [15:0] irq_status,
    input logic [15:0] irq_mask,
    input logic [15:0] smp_reg,
    input logic [15:0] stat_reg
);
    import pmr_pkg::*;

    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 16'hFFFF) |-> !irq);

    assert_adc_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && idx == IX_ADC) |=> irq_status[IRQ_ADC_BIT]);

    assert_smp_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && idx == IX_SMP) |=> ((smp_reg & $past(wdata)) == '0));

    assert_wdog_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> $past(req && we && idx == IX_WDOG && wdata == '0));

    assert_key_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        key_evt |=> (irq_status[IRQ_KEY_BIT] && (stat_reg[KEY_STAT_BIT] == !$past(key_down))));

    assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind pmr_regfile pmr_regfile_chk u_chk (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .req        (req_i),
    .we         (we_i),
    .idx        (idx_i),
    .wdata      (wdata_i),
    .key_evt    (key_evt_i),
    .key_down   (key_down_i),
    .irq        (irq_o),
    .shutdown   (shutdown_o),
    .err        (err_o),
    .irq_status (irq_status),
    .irq_mask   (irq_mask),
    .smp_reg    (q.smp),
    .stat_reg   (q.stat)
);

// File: tb/sim_pmr_regfile.sv
`timescale 1ns/1ps
module sim_pmr_regfile;
    localparam logic [15:0] T_USED = 16'h7FF6;
    localparam logic [15:0] T_SMP  = 16'hF0F3;

    function automatic logic [159:0] build_tab();
        logic [159:0] t;
        for (int i = 0; i < 16; i++) t[i*10 +: 10] = 10'((i * 71 + 13) & 1023);
        return t;
    endfunction
    localparam logic [159:0] T_TAB = build_tab();

    logic clk = 0, rst_n = 0, variant = 1;
    logic req = 0, we = 0, kev = 0, kdn = 0;
    logic [4:0]  idx = '0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic irq, shut, err;

    always #5 clk = ~clk;

    pmr_regfile #(.CH_W(4), .RES_W(10), .ADC_INIT(T_TAB), .ADC_USED(T_USED), .SMP_RST(T_SMP)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .req_i(req), .we_i(we),
        .idx_i(idx), .wdata_i(wd), .rdata_o(rdata), .key_evt_i(kev), .key_down_i(kdn),
        .irq_o(irq), .shutdown_o(shut), .err_o(err)
    );

    int total = 0, bad = 0;
    logic [15:0] m_st, m_mask, m_cal, m_smp, m_c1, m_c2, m_stat, m_rd;
    logic [3:0]  m_ch;
    logic        m_err, m_shut;

    function automatic logic is_undef(logic [4:0] i);
        return (i == 5'h07) || (i >= 5'h12 && i <= 5'h15);
    endfunction

    function automatic logic [15:0] exp_rd(logic [4:0] i);
        case (i)
            5'h00: return 16'h0215 | (16'(variant) << 7);
            5'h01: return m_st;
            5'h02: return m_mask;
            5'h06: return m_cal;
            5'h08: return {2'b00, m_ch, (T_USED[m_ch] ? 10'((m_ch * 71 + 13) & 1023) : 10'd0)};
            5'h09: return m_smp;
            5'h0D: return m_c1;
            5'h0E: return m_c2;
            5'h16: return m_stat;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] i);
        case (i)
            5'h00: return "R5";
            5'h01: return "R3";
            5'h02: return "R4";
            5'h06, 5'h0D, 5'h0E: return "R9";
            5'h08: return "R6";
            5'h09: return "R8";
            5'h16: return "R11";
            5'h17: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic post_chk(input string tag);
        chk(16'(irq), 16'(|(m_st & ~m_mask)), "R2");
        chk(16'(shut), 16'(m_shut), tag);
        chk(16'(err), 16'(m_err), "R13");
        chk(rdata, m_rd, "R14");
    endtask

    task automatic wr(input logic [4:0] i, input logic [15:0] v, input string tag);
        @(negedge clk);
        req = 1; we = 1; idx = i; wd = v;
        @(negedge clk);
        req = 0; we = 0;
        m_shut = 1'b0;
        case (i)
            5'h01: m_st = m_st ^ v;
            5'h02: m_mask = v;
            5'h06: m_cal = v;
            5'h08: begin m_ch = v[13:10]; m_st[8] = 1'b1; end
            5'h09: m_smp = m_smp & ~v;
            5'h0D: m_c1 = v;
            5'h0E: m_c2 = v;
            5'h17: m_shut = (v == 16'h0000) && m_c1[1];
            default: if (is_undef(i)) m_err = 1'b1;
        endcase
        post_chk(tag);
    endtask

    task automatic rd(input logic [4:0] i, input string tag);
        logic [15:0] e;
        e = exp_rd(i);
        @(negedge clk);
        req = 1; we = 0; idx = i;
        @(negedge clk);
        req = 0;
        m_shut = 1'b0;
        if (is_undef(i)) m_err = 1'b1;
        chk(rdata, e, tag);
        m_rd = e;
        post_chk(tag);
    endtask

    task automatic key(input logic down, input logic also_xor, input logic [15:0] v);
        @(negedge clk);
        kev = 1; kdn = down;
        if (also_xor) begin req = 1; we = 1; idx = 5'h01; wd = v; end
        @(negedge clk);
        kev = 0; req = 0; we = 0;
        m_shut = 1'b0;
        if (also_xor) m_st = m_st ^ v;
        m_st[0] = 1'b1;
        m_stat[5] = ~down;
        post_chk("R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_st = 0; m_mask = 16'hFFFF; m_cal = 16'h0001; m_smp = T_SMP;
        m_c1 = 0; m_c2 = 0; m_stat = 16'h0020; m_ch = 0; m_err = 0; m_shut = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state at the ports and through a full read sweep
        post_chk("R1");
        for (int i = 0; i < 32; i++)
            if (!is_undef(5'(i))) rd(5'(i), "R1");

        // write sweep over every decoded or reserved index, then read back (R3 R4 R5 R9 R11 R13)
        for (int i = 0; i < 32; i++)
            if (!is_undef(5'(i)) && i != 8 && i != 9)
                wr(5'(i), 16'h5A3C ^ 16'(i * 16'h0421) | 16'h0100, tag_of(5'(i)));
        for (int i = 0; i < 32; i++)
            if (!is_undef(5'(i))) rd(5'(i), tag_of(5'(i)));

        // R2: each mask bit in turn against a toggled status bit
        wr(5'h01, m_st, "R3");
        for (int b = 0; b < 16; b++) begin
            wr(5'h02, ~(16'h1 << b), "R4");
            wr(5'h01, 16'h1 << b, "R2");
            wr(5'h01, 16'hFFFF ^ (16'h1 << b), "R2");
            wr(5'h01, m_st, "R3");
        end

        // R6 R7: every channel
        for (int c = 0; c < 16; c++) begin
            wr(5'h08, (16'(c) << 10) | 16'hC3FF, "R6");
            rd(5'h08, T_USED[c] ? "R6" : "R7");
            rd(5'h01, "R6");
            wr(5'h01, m_st, "R3");
        end

        // R8: write-one-to-clear patterns
        rd(5'h09, "R8");
        wr(5'h09, 16'h0003, "R8"); rd(5'h09, "R8");
        wr(5'h09, 16'h0000, "R8"); rd(5'h09, "R8");
        wr(5'h09, 16'hA0F0, "R8"); rd(5'h09, "R8");
        wr(5'h09, 16'hFFFF, "R8"); rd(5'h09, "R8");

        // R10: watchdog arming
        wr(5'h0D, 16'hFFFD, "R9");
        wr(5'h17, 16'h0000, "R10");
        wr(5'h0D, 16'h0002, "R9");
        wr(5'h17, 16'h0001, "R10");
        wr(5'h17, 16'h0000, "R10");
        @(negedge clk);
        chk(16'(shut), 16'h0, "R10");
        rd(5'h17, "R10");

        // R11: key press and release, status word read-only
        key(1'b1, 1'b0, 16'h0); rd(5'h16, "R11"); rd(5'h01, "R11");
        key(1'b0, 1'b0, 16'h0); rd(5'h16, "R11");
        wr(5'h16, 16'h0000, "R11"); rd(5'h16, "R11");

        // R12: XOR of bit 0 coincident with a key event leaves bit 0 set
        key(1'b1, 1'b1, 16'h0001); rd(5'h01, "R12");
        key(1'b0, 1'b1, 16'h0011); rd(5'h01, "R12");

        // R5: variant strap low
        variant = 0; rd(5'h00, "R5");
        wr(5'h00, 16'hFFFF, "R5"); rd(5'h00, "R5");

        // R14: rdata holds over idle cycles and writes
        rd(5'h06, "R14");
        repeat (3) @(negedge clk);
        chk(rdata, m_rd, "R14");
        wr(5'h06, 16'h1234, "R14");
        rd(5'h06, "R9");

        // R13: undefined indices, sticky error
        chk(16'(err), 16'h0, "R13");
        wr(5'h07, 16'hFFFF, "R13");
        rd(5'h12, "R13");
        for (int i = 18; i <= 21; i++) wr(5'(i), 16'hBEEF, "R13");
        rd(5'h15, "R13");
        rd(5'h07, "R13");
        repeat (4) @(negedge clk);
        chk(16'(err), 16'h1, "R13");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule